// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This unit measures how far apart two pixel blocks are. Each block is a 256-entry array of unsigned bytes kept in an external memory. After a start pulse, the unit steps one shared address through both memories. At every address it takes one byte from each array and adds the magnitude of their difference to a 32-bit running total. When every address has been visited, the total is copied into an output register. That register keeps the value until the next run finishes.

Surrounding logic compares the result against a threshold. It uses that comparison to choose between sending a whole frame and sending only the change. That decision is made outside this unit. The two memories must return data in the same cycle that the address is presented. The memory interface is a plain address-and-strobe port with no handshake: the unit never stalls, and the memories can never push back. A run takes a fixed number of cycles, with two controller steps for each element.

Top module: `sad_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `sad` reads 0 and `mem_rd` is low.
- R2: A completed run leaves `sad` equal to the sum of |A[k] − B[k]| over all 256 addresses, with A and B as unsigned bytes. The magnitude is correct whichever operand is larger, so it never wraps.
- R3: The new `sad` value appears on the 515th rising edge after the edge that samples `go` high in the idle state. In general this is 2·N + 3 edges for N elements.
- R4: Within one run, `mem_rd` is high for exactly 256 single cycles, never in two cycles in a row. `mem_addr` carries 0, 1, …, 255 in that order in those cycles.
- R5: `sad` does not change except when a run completes, and it holds its previous value for the whole of a run.
- R6: A `go` pulse that arrives while a run is in progress has no effect: it neither restarts nor lengthens the run.
- R7: While the unit is idle, `mem_rd` stays low.
- R8: The extreme operands give the exact extreme results. Identical blocks give 0. All-255 against all-0 gives 65280 in either operand order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, sampled only while idle |
| mem_addr | output | 8 | Shared address into both operand memories |
| mem_rd | output | 1 | Read strobe; the data on `a_data`/`b_data` is consumed in this cycle |
| a_data | input | 8 | Byte from operand memory A at `mem_addr` |
| b_data | input | 8 | Byte from operand memory B at `mem_addr` |
| sad | output | 32 | Registered sum of absolute differences from the last completed run |

## Verification
All results follow a fixed schedule counted from the rising edge that samples `go`. The k-th read strobe is visible after edge 2k, for k = 1…256. The result register changes on edge 515, and nowhere earlier. Each run task counts edges from the start edge and samples the outputs on the falling edge after each one. It compares the strobe and address against the element count reached so far. It requires `sad` to keep its old value through edge 514 and to hold the independently computed total after edge 515. It then watches several idle cycles to confirm that no stray restart occurs.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_TEST = 3'd2,
    ST_ACC  = 3'd3,
    ST_LOAD = 3'd4
  } sad_state_e;

  typedef struct packed {
    logic tot_clr;
    logic tot_add;
    logic idx_clr;
    logic idx_step;
    logic res_load;
    logic rd;
  } sad_ctl_t;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       idx_below,
  output sad_ctl_t   ctl,
  output sad_state_e st_o
);

  sad_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = ST_INIT;
      ST_INIT: st_d = ST_TEST;
      ST_TEST: st_d = idx_below ? ST_ACC : ST_LOAD;
      ST_ACC:  st_d = ST_TEST;
      ST_LOAD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (st_q)
      ST_INIT: begin
        ctl.tot_clr = 1'b1;
        ctl.idx_clr = 1'b1;
      end
      ST_ACC: begin
        ctl.tot_add  = 1'b1;
        ctl.idx_step = 1'b1;
        ctl.rd       = 1'b1;
      end
      ST_LOAD: ctl.res_load = 1'b1;
      default: ctl = '0;
    endcase
  end

  assign st_o = st_q;

endmodule

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] mag
);

  logic x_ge_y;

  assign x_ge_y = (x >= y);
  assign mag    = x_ge_y ? (x - y) : (y - x);

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SUM_W    = 32,
  parameter int NUM_ELEM = 256,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sad_ctl_t          ctl,
  input  logic [DATA_W-1:0] a_data,
  input  logic [DATA_W-1:0] b_data,
  output logic              idx_below,
  output logic [ADDR_W-1:0] addr,
  output logic [SUM_W-1:0]  result
);

  localparam int IDX_W = $clog2(NUM_ELEM + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [SUM_W-1:0]  tot_q;
  logic [SUM_W-1:0]  res_q;
  logic [DATA_W-1:0] mag;

  sad_absdiff #(.DATA_W(DATA_W)) u_absdiff (
    .x   (a_data),
    .y   (b_data),
    .mag (mag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            idx_q <= '0;
    else if (ctl.idx_clr)  idx_q <= '0;
    else if (ctl.idx_step) idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           tot_q <= '0;
    else if (ctl.tot_clr) tot_q <= '0;
    else if (ctl.tot_add) tot_q <= tot_q + SUM_W'(mag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            res_q <= '0;
    else if (ctl.res_load) res_q <= tot_q;
  end

  assign idx_below = (idx_q < IDX_W'(NUM_ELEM));
  assign addr      = idx_q[ADDR_W-1:0];
  assign result    = res_q;

endmodule

// File: rtl/sad_engine.sv
module sad_engine
  import sad_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SUM_W    = 32,
  parameter int NUM_ELEM = 256,
  parameter int ADDR_W   = $clog2(NUM_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] a_data,
  input  logic [DATA_W-1:0] b_data,
  output logic [SUM_W-1:0]  sad
);

  sad_ctl_t   ctl;
  sad_state_e ctrl_st;
  logic       idx_below;

  sad_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .idx_below (idx_below),
    .ctl       (ctl),
    .st_o      (ctrl_st)
  );

  sad_datapath #(
    .DATA_W   (DATA_W),
    .SUM_W    (SUM_W),
    .NUM_ELEM (NUM_ELEM),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .a_data    (a_data),
    .b_data    (b_data),
    .idx_below (idx_below),
    .addr      (mem_addr),
    .result    (sad)
  );

  assign mem_rd = ctl.rd;

endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk
  import sad_pkg::*;
#(
  parameter int SUM_W    = 32,
  parameter int NUM_ELEM = 256,
  parameter int ADDR_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SUM_W-1:0]  sad,
  input sad_state_e        st
);

  localparam int CNT_W = $clog2(NUM_ELEM + 1) + 1;

  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             rd_cnt <= '0;
    else if (st == ST_INIT) rd_cnt <= '0;
    else if (mem_rd)        rd_cnt <= rd_cnt + 1'b1;
  end

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R4
  addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd, 2)) |-> (mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)));

  // R4
  rd_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD) |-> (rd_cnt == CNT_W'(NUM_ELEM)));

  // R5
  sad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_LOAD) |=> $stable(sad));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> (st != ST_INIT));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !mem_rd);

endmodule

bind sad_engine sad_engine_chk #(
  .SUM_W    (SUM_W),
  .NUM_ELEM (NUM_ELEM),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .sad      (sad),
  .st       (ctrl_st)
);

// File: tb/sad_engine_tb_top.sv
`timescale 1ns/1ps
module sad_engine_tb_top;

  localparam int N = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_rd;
  logic [7:0]  a_data;
  logic [7:0]  b_data;
  logic [31:0] sad;

  logic [7:0] a_mem [N];
  logic [7:0] b_mem [N];

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  assign a_data = a_mem[mem_addr];
  assign b_data = b_mem[mem_addr];

  sad_engine dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .a_data   (a_data),
    .b_data   (b_data),
    .sad      (sad)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sad();
    logic [31:0] s = 0;
    for (int k = 0; k < N; k++)
      s += (a_mem[k] >= b_mem[k]) ? 32'(a_mem[k] - b_mem[k]) : 32'(b_mem[k] - a_mem[k]);
    return s;
  endfunction

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sad == 0, "R1 sad in reset", sad, 0);
    check(mem_rd == 0, "R1 rd in reset", mem_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sad == 0 && mem_rd == 0, "R1 after reset", sad, 0);
  endtask

  // R7: idle with no go must stay quiet and hold sad
  task automatic t_idle(input int cycles);
    logic [31:0] old = sad;
    int          rd_seen = 0;
    int          chg = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (mem_rd) rd_seen++;
      if (sad != old) chg++;
    end
    check(rd_seen == 0, "R7 idle strobe count", rd_seen, 0);
    check(chg == 0, "R5 idle sad hold", chg, 0);
  endtask

  // R2 R3 R4 R5 R6
  task automatic t_run(input string name, input bit poke);
    logic [31:0] exp = ref_sad();
    logic [31:0] old;
    int          rd_cnt = 0;
    int          bad_addr = 0;
    int          early_chg = 0;
    int          back2back = 0;
    bit          prev_rd = 0;
    @(negedge clk);
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go  = 1'b0;
    old = sad;
    for (int k = 1; k <= 2 * N + 3; k++) begin
      @(negedge clk);
      if (poke && (k == 100 || k == 2 * N + 1)) go = 1'b1;
      else                                      go = 1'b0;
      if (mem_rd) begin
        if (prev_rd) back2back++;
        if (mem_addr != 8'(rd_cnt)) bad_addr++;
        rd_cnt++;
      end
      prev_rd = mem_rd;
      if (k < 2 * N + 3 && sad != old) early_chg++;
    end
    go = 1'b0;
    $display("[TB] run %s expected %0d", name, exp);
    check(rd_cnt == N, "R4 strobe count", rd_cnt, N);
    check(bad_addr == 0, "R4 address order", bad_addr, 0);
    check(back2back == 0, "R4 single-cycle strobes", back2back, 0);
    check(early_chg == 0, "R5 sad held during run", early_chg, 0);
    check(sad == exp, "R2 R3 sad on edge 515", sad, exp);
    if (poke) check(sad == exp, "R6 mid-run go ignored", sad, exp);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin a_mem[k] = 8'(k); b_mem[k] = 8'(k); end
    t_reset();
    t_idle(10);

    // R8 identical blocks
    t_run("equal", 1'b0);
    check(sad == 0, "R8 equal blocks", sad, 0);
    t_idle(8);

    // R8 max, A larger
    for (int k = 0; k < N; k++) begin a_mem[k] = 8'hFF; b_mem[k] = 8'h00; end
    t_run("a_max", 1'b0);
    check(sad == 65280, "R8 all 255 vs 0", sad, 65280);

    // R8 max, B larger (no wrap)
    for (int k = 0; k < N; k++) begin a_mem[k] = 8'h00; b_mem[k] = 8'hFF; end
    t_run("b_max", 1'b0);
    check(sad == 65280, "R8 all 0 vs 255", sad, 65280);
    t_idle(8);

    // R2 crossing ramps
    for (int k = 0; k < N; k++) begin a_mem[k] = 8'(k); b_mem[k] = 8'(255 - k); end
    t_run("ramps", 1'b0);

    // R6 pseudo-random data with go pokes during the run
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < N; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a_mem[k] = lf[7:0];
        b_mem[k] = lf[15:8];
      end
    end
    t_run("lfsr_poke", 1'b1);
    t_idle(12);

    // R5 value held across a run on new data, then replaced
    for (int k = 0; k < N; k++) begin a_mem[k] = 8'(k[2:0]); b_mem[k] = 8'd3; end
    t_run("small", 1'b0);
    t_idle(5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule